// File: doc/BRIEF.md
# Autovector Interrupt Acknowledge Controller

This block connects a single interrupt-capable expansion card to a 68000-style CPU bus. While the card requests service, the block encodes a fixed priority level (level 5 by default) onto the active-low priority request lines. When the CPU later runs an interrupt acknowledge cycle for that level, the block answers with the active-low autovector strobe. The CPU then takes its vector from the autovector table and does not wait for a vector number from the card.

A policy input selects one of two ways to answer the acknowledge. In conditional policy the block answers only while the card is still requesting. This leaves a same-level acknowledge with no card request free for another vectored device. In unconditional policy every acknowledge at the block's level is autovectored. This covers the case where the card withdraws its request after the CPU has seen it: without an answer, that acknowledge cycle would end in a bus error. The policy is captured only between bus cycles.

Top module: `avi_autovector_ctrl`

## Requirements
- R1: After reset, with no card request, the priority lines read 3'b111 and the autovector strobe is high (negated).
- R2: A card request passes through a two-stage synchroniser. The priority lines change to 3'b010 (active-low level 5) on the second clock edge after the request rises. They return to 3'b111 on the second edge after it falls.
- R3: An interrupt acknowledge is a cycle with function code 3'b111 and address strobe low, carrying the level on A3..A1. When the level is 3'b101 and the cycle qualifies, the autovector strobe goes low on the first clock edge after the acknowledge is presented.
- R4: In conditional policy (mode input 0), a level-5 acknowledge gets the autovector strobe while the synchronised card request is active.
- R5: In conditional policy, a level-5 acknowledge with no synchronised card request gets no autovector strobe for the whole cycle. This includes a request withdrawn before the acknowledge.
- R6: In unconditional policy (mode input 1), every level-5 acknowledge gets the autovector strobe, whether or not a card request is present.
- R7: The autovector strobe returns high in the same cycle that address strobe goes high, with no clock edge in between.
- R8: Cycles with a function code other than 3'b111, and acknowledges for any level other than 3'b101, never assert the autovector strobe.
- R9: The policy input is captured only on clock edges where address strobe is high. A change while address strobe is low has no effect on the current cycle.
- R10: Once asserted, the autovector strobe stays low until address strobe goes high, even if the card withdraws its request during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_i | input | 3 | CPU function code |
| lvl_i | input | 3 | Acknowledged level (address bits 3..1) |
| as_n_i | input | 1 | Address strobe, active low |
| card_req_i | input | 1 | Card interrupt request, active high, asynchronous |
| mode_i | input | 1 | Policy: 0 conditional, 1 unconditional |
| ipl_n_o | output | 3 | Encoded priority request, active low |
| vpa_n_o | output | 1 | Autovector strobe, active low |

## Verification
The bench builds the block with its default parameters: a two-stage synchroniser and level 5. With these values the exact two-edge request latency can be counted and checked, and the level pattern 3'b101 is the one used to tell a matching acknowledge from other levels. The bench covers both policies against a request that is present, one that was never made, one withdrawn before the acknowledge, and one withdrawn during it. It also changes the policy in the middle of a cycle.

// File: rtl/avi_pkg.sv
package avi_pkg;
    localparam int FC_W  = 3;
    localparam int LVL_W = 3;

    localparam logic [FC_W-1:0] FC_CPU_SPACE = '1;

    typedef enum logic {
        POL_CONDITIONAL   = 1'b0,
        POL_UNCONDITIONAL = 1'b1
    } policy_e;

    typedef struct packed {
        logic    vpa;
        policy_e pol;
    } resp_state_t;
endpackage

// File: rtl/avi_sync.sv
module avi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/avi_iack_decode.sv
module avi_iack_decode
    import avi_pkg::*;
#(
    parameter int LEVEL = 5
) (
    input  logic [FC_W-1:0]  fc_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             as_n_i,
    input  logic             req_s_i,
    output logic             iack_match_o,
    output logic [LVL_W-1:0] ipl_n_o
);
    localparam logic [LVL_W-1:0] LVL_CODE = LVL_W'(LEVEL);

    always_comb begin
        iack_match_o = (fc_i == FC_CPU_SPACE) && !as_n_i && (lvl_i == LVL_CODE);
        ipl_n_o      = req_s_i ? ~LVL_CODE : '1;
    end
endmodule

// File: rtl/avi_vpa_ctrl.sv
module avi_vpa_ctrl
    import avi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_n_i,
    input  logic mode_i,
    input  logic iack_match_i,
    input  logic req_s_i,
    output logic vpa_n_o,
    output logic pol_uncond_o
);
    resp_state_t st_d, st_q;
    logic        qualify;

    always_comb begin
        st_d    = st_q;
        qualify = iack_match_i && ((st_q.pol == POL_UNCONDITIONAL) || req_s_i);
        if (as_n_i) begin
            st_d.pol = policy_e'(mode_i);
            st_d.vpa = 1'b0;
        end else if (qualify) begin
            st_d.vpa = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{vpa: 1'b0, pol: POL_CONDITIONAL};
        else        st_q <= st_d;
    end

    assign vpa_n_o      = ~(st_q.vpa && !as_n_i);
    assign pol_uncond_o = (st_q.pol == POL_UNCONDITIONAL);

    p_policy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n_i && $past(!as_n_i)) |-> $stable(pol_uncond_o));

    p_vpa_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpa_n_o && !as_n_i) |=> (!vpa_n_o || as_n_i));
endmodule

// File: rtl/avi_autovector_ctrl.sv
module avi_autovector_ctrl
    import avi_pkg::*;
#(
    parameter int LEVEL       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FC_W-1:0]  fc_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             as_n_i,
    input  logic             card_req_i,
    input  logic             mode_i,
    output logic [LVL_W-1:0] ipl_n_o,
    output logic             vpa_n_o
);
    logic req_s;
    logic iack_match;
    logic pol_uncond;

    avi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (card_req_i),
        .sync_o  (req_s)
    );

    avi_iack_decode #(.LEVEL(LEVEL)) u_dec (
        .fc_i         (fc_i),
        .lvl_i        (lvl_i),
        .as_n_i       (as_n_i),
        .req_s_i      (req_s),
        .iack_match_o (iack_match),
        .ipl_n_o      (ipl_n_o)
    );

    avi_vpa_ctrl u_vpa (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_n_i       (as_n_i),
        .mode_i       (mode_i),
        .iack_match_i (iack_match),
        .req_s_i      (req_s),
        .vpa_n_o      (vpa_n_o),
        .pol_uncond_o (pol_uncond)
    );

    p_ipl_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_n_o == (req_s ? ~LVL_W'(LEVEL) : {LVL_W{1'b1}}));

    p_vpa_only_iack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !vpa_n_o |-> (fc_i == FC_CPU_SPACE && lvl_i == LVL_W'(LEVEL) && !as_n_i));

    p_uncond_answer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_match && pol_uncond) |=> (!vpa_n_o || as_n_i));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        as_n_i |-> vpa_n_o);
endmodule

// File: tb/avi_autovector_ctrl_tb_top.sv
module avi_autovector_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fc = 3'b000;
    logic [2:0] lvl = 3'b000;
    logic       as_n = 1'b1;
    logic       req = 1'b0;
    logic       mode = 1'b0;
    logic [2:0] ipl_n;
    logic       vpa_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    avi_autovector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fc_i(fc), .lvl_i(lvl), .as_n_i(as_n),
        .card_req_i(req), .mode_i(mode), .ipl_n_o(ipl_n), .vpa_n_o(vpa_n)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string rq, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", rq, act, exp);
        end
    endtask

    task automatic idle_bus();
        as_n = 1'b1; fc = 3'b101; lvl = 3'b000;
    endtask

    task automatic set_policy(input logic m);
        idle_bus(); mode = m; step(1);
    endtask

    task automatic start_iack(input logic [2:0] l);
        fc = 3'b111; lvl = l; as_n = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ipl", ipl_n, 3'b111);
        chk("R1 vpa", {2'b0, vpa_n}, 3'b001);
    endtask

    task automatic t_request_latency();
        req = 1'b1; step(1);
        chk("R2 ipl after one edge", ipl_n, 3'b111);
        step(1);
        chk("R2 ipl after two edges", ipl_n, 3'b010);
        req = 1'b0; step(1);
        chk("R2 ipl one edge after drop", ipl_n, 3'b010);
        step(1);
        chk("R2 ipl two edges after drop", ipl_n, 3'b111);
    endtask

    task automatic t_cond_with_req();
        set_policy(1'b0);
        req = 1'b1; step(2);
        start_iack(3'b101);
        chk("R3 vpa before edge", {2'b0, vpa_n}, 3'b001);
        step(1);
        chk("R4 R3 vpa asserted", {2'b0, vpa_n}, 3'b000);
        req = 1'b0; step(3);
        chk("R10 vpa held after withdrawal", {2'b0, vpa_n}, 3'b000);
        as_n = 1'b1;
        #1;
        chk("R7 vpa released with AS", {2'b0, vpa_n}, 3'b001);
        step(2);
    endtask

    task automatic t_cond_no_req();
        set_policy(1'b0);
        req = 1'b1; step(2);
        req = 1'b0; step(2);
        start_iack(3'b101); step(4);
        chk("R5 no vpa after early withdrawal", {2'b0, vpa_n}, 3'b001);
        idle_bus(); step(1);
    endtask

    task automatic t_uncond();
        set_policy(1'b1);
        start_iack(3'b101); step(1);
        chk("R6 vpa without request", {2'b0, vpa_n}, 3'b000);
        idle_bus(); #1;
        chk("R7 release", {2'b0, vpa_n}, 3'b001);
        step(1);
        req = 1'b1; step(2);
        start_iack(3'b101); step(1);
        chk("R6 vpa with request", {2'b0, vpa_n}, 3'b000);
        idle_bus(); req = 1'b0; step(3);
    endtask

    task automatic t_other_cycles();
        set_policy(1'b1);
        for (int l = 0; l < 8; l++) begin
            if (l != 5) begin
                start_iack(3'(l)); step(2);
                chk("R8 other level", {2'b0, vpa_n}, 3'b001);
                idle_bus(); step(1);
            end
        end
        fc = 3'b110; lvl = 3'b101; as_n = 1'b0; step(2);
        chk("R8 non-acknowledge fc", {2'b0, vpa_n}, 3'b001);
        idle_bus(); step(1);
    endtask

    task automatic t_policy_freeze();
        set_policy(1'b0);
        start_iack(3'b101); step(1);
        mode = 1'b1; step(3);
        chk("R9 mid-cycle switch to unconditional ignored", {2'b0, vpa_n}, 3'b001);
        idle_bus(); step(1);
        start_iack(3'b101); mode = 1'b0; step(1);
        chk("R9 new policy taken between cycles", {2'b0, vpa_n}, 3'b000);
        idle_bus(); step(1);
    endtask

    initial begin
        step(2);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_request_latency();
        t_cond_with_req();
        t_cond_no_req();
        t_uncond();
        t_other_cycles();
        t_policy_freeze();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule